// File: doc/BRIEF.md
# Four-Channel DMA Control Register Bank and Grant Scanner

This block holds the controller-wide state of a four-channel DMA engine. Software reaches it through a byte-wide port with a 3-bit register index. Writes set the command word, the request bits, the channel masks and the per-channel mode bytes, and one index acts as a master clear. Reads return a status byte or the mask. A one-bit byte pointer is also kept here for the neighbouring address and count logic. That logic toggles the pointer on each of its port accesses, and this block clears it.

From the mask and request bits the block works out which channels may be serviced. It then grants the lowest-numbered one, unless the controller has been disabled through the command word. Device-side hold and release inputs drive the request bits directly. A per-channel done pulse sets that channel's terminal-count status bit. The status byte carries the request bits in its upper nibble and the terminal-count bits in its lower nibble.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, all four mask bits are 1, and the status byte, the disable flag, the byte pointer and every mode byte are 0.
- R2: A write to index 0 is dropped unless the data is 0x00 or 0x04. When it is accepted, data bit 2 becomes the disable flag shown on `ctl_disabled`.
- R3: A write to index 1 selects channel `wr_data[1:0]`. It sets that channel's request bit (status bit channel+4) when `wr_data[2]` is 1 and clears it otherwise. The same write clears that channel's terminal-count bit (status bit channel).
- R4: A write to index 2 sets the mask bit of channel `wr_data[1:0]` when `wr_data[2]` is 1 and clears it otherwise.
- R5: A write to index 3 stores the whole data byte as the mode byte of channel `wr_data[1:0]`. It appears on `mode_all[8*ch+7:8*ch]`, with transfer type in bits 3:2, auto-init in bit 4, decrement in bit 5 and mode in bits 7:6.
- R6: A write to index 5 sets every mask bit and clears the status byte, the disable flag and the byte pointer, overriding all other inputs in that cycle. Mode bytes are left unchanged.
- R7: A write to index 6 clears all mask bits. A write to index 7 loads the mask from `wr_data[3:0]`.
- R8: Each `addr_access` pulse toggles `byte_ptr`. A write to index 4 clears it, and the clear wins over a toggle in the same cycle.
- R9: With `rd_en` high, `rd_data` shows {request nibble, terminal-count nibble} for index 0, {4'h0, mask} for index 1, and 0 for any other index. A status read clears the terminal-count nibble at the following clock edge.
- R10: A `done[ch]` pulse sets terminal-count bit ch. This set wins over a status-read clear or a request-write clear in the same cycle.
- R11: `hold_req[ch]` sets and `release_req[ch]` clears request bit ch, and release wins over hold. An index-1 write to the same channel in the same cycle overrides both.
- R12: `grant` is one-hot or zero. It marks the lowest-numbered channel whose mask bit is 0 and whose request bit is 1, and it is zero while the disable flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| hold_req | input | 4 | Per-channel request set from devices |
| release_req | input | 4 | Per-channel request clear from devices |
| done | input | 4 | Per-channel terminal-count pulse |
| addr_access | input | 1 | Toggle for the byte pointer |
| grant | output | 4 | One-hot service grant |
| ctl_disabled | output | 1 | Controller disable flag |
| byte_ptr | output | 1 | Byte pointer for the address and count ports |
| mode_all | output | 32 | Four mode bytes, channel 0 in the low byte |

## Verification
The assertions assume that each clock carries at most one register write. They also assume the strobes and data never hold X after reset. The grant checks assume the request and mask state only changes through the port and the hold, release and done pins. The stimulus drives every input fully at each falling edge and returns them to zero between operations. It deliberately combines a status read with a done pulse, and a hold with a request write, so that the precedence rules are covered.

// File: rtl/dma_ctl_regs.sv
`timescale 1ns/1ps
module dma_ctl_regs #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       reg_idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [NCH-1:0]   hold_req,
  input  logic [NCH-1:0]   release_req,
  input  logic [NCH-1:0]   done,
  input  logic             addr_access,
  output logic [NCH-1:0]   grant,
  output logic             ctl_disabled,
  output logic             byte_ptr,
  output logic [8*NCH-1:0] mode_all
);
  localparam int CW = $clog2(NCH);

  logic [NCH-1:0] mask_q, req_q, tc_q;
  logic [NCH-1:0] mask_n, req_n, tc_n;
  logic           dis_q, ptr_q;
  logic [7:0]     mode_q [NCH];

  wire            w_cmd  = wr_en && reg_idx == 3'd0;
  wire            w_req  = wr_en && reg_idx == 3'd1;
  wire            w_smsk = wr_en && reg_idx == 3'd2;
  wire            w_mode = wr_en && reg_idx == 3'd3;
  wire            w_ptr  = wr_en && reg_idx == 3'd4;
  wire            w_mclr = wr_en && reg_idx == 3'd5;
  wire            w_mclx = wr_en && reg_idx == 3'd6;
  wire            w_mall = wr_en && reg_idx == 3'd7;
  wire            r_stat = rd_en && reg_idx == 3'd0;
  wire [CW-1:0]   wch    = wr_data[CW-1:0];
  wire [NCH-1:0]  wsel   = NCH'(1) << wch;
  wire            cmd_ok = (wr_data & 8'hFB) == 8'h00;
  wire [NCH-1:0]  elig   = ~mask_q & req_q;

  always_comb begin
    req_n = (req_q | hold_req) & ~release_req;
    if (w_req) req_n = wr_data[2] ? (req_n | wsel) : (req_n & ~wsel);
    tc_n = r_stat ? '0 : tc_q;
    if (w_req) tc_n = tc_n & ~wsel;
    tc_n = tc_n | done;
    mask_n = mask_q;
    if (w_smsk) mask_n = wr_data[2] ? (mask_q | wsel) : (mask_q & ~wsel);
    if (w_mclx) mask_n = '0;
    if (w_mall) mask_n = wr_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      dis_q  <= 1'b0;
      ptr_q  <= 1'b0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= 8'h00;
    end else if (w_mclr) begin
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      dis_q  <= 1'b0;
      ptr_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      req_q  <= req_n;
      tc_q   <= tc_n;
      if (w_cmd && cmd_ok) dis_q <= wr_data[2];
      if (w_ptr) ptr_q <= 1'b0;
      else if (addr_access) ptr_q <= ~ptr_q;
      if (w_mode) mode_q[wch] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (reg_idx)
        3'd0:    rd_data = {req_q, tc_q};
        3'd1:    rd_data = {{(8-NCH){1'b0}}, mask_q};
        default: rd_data = 8'h00;
      endcase
    end
  end

  assign grant        = dis_q ? '0 : (elig & (~elig + NCH'(1)));
  assign ctl_disabled = dis_q;
  assign byte_ptr     = ptr_q;

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    assign mode_all[8*g +: 8] = mode_q[g];
  end

  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (!dis_q && (grant & (mask_q | ~req_q)) == '0));
  assert_grant_lowest_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (((grant - NCH'(1)) & ~mask_q & req_q) == '0));
  assert_cmd_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmd && !cmd_ok) |=> $stable(dis_q));
  assert_done_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((done != '0) && !w_mclr) |=> ((tc_q & $past(done)) == $past(done)));
  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stat && done == '0) |=> (tc_q == '0));
  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_mall |=> (mask_q == $past(wr_data[NCH-1:0])));
  assert_master_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    w_mclr |=> (mask_q == '1 && req_q == '0 && tc_q == '0 && !dis_q && !ptr_q));
endmodule

// File: tb/dma_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module dma_ctl_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, addr_access = 0;
  logic [2:0] reg_idx = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [3:0] hold_req = '0, release_req = '0, done = '0, grant;
  logic ctl_disabled, byte_ptr;
  logic [31:0] mode_all;

  dma_ctl_regs dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data), .hold_req(hold_req),
    .release_req(release_req), .done(done), .addr_access(addr_access),
    .grant(grant), .ctl_disabled(ctl_disabled), .byte_ptr(byte_ptr),
    .mode_all(mode_all));

  always #2 clk = ~clk;

  typedef struct { int due; int kind; logic [7:0] exp; string req; } item_t;
  item_t sbq[$];
  int cyc = 0, n_tests = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // kinds: 0 rd_data, 1 grant, 2 ctl_disabled, 3 byte_ptr, 4..7 mode of channel kind-4
  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [7:0] obs;
      it = sbq.pop_front();
      case (it.kind)
        0: obs = rd_data;
        1: obs = {4'h0, grant};
        2: obs = {7'h0, ctl_disabled};
        3: obs = {7'h0, byte_ptr};
        default: obs = mode_all[8*(it.kind-4) +: 8];
      endcase
      n_tests++;
      if (obs !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind %0d: actual %02h expected %02h", it.req, it.kind, obs, it.exp);
      end
    end
  end

  task automatic drive(input logic w, input logic [2:0] idx, input logic [7:0] d,
                       input logic r, input logic [3:0] h, input logic [3:0] rl,
                       input logic [3:0] dn, input logic a);
    @(negedge clk);
    wr_en = w; reg_idx = idx; wr_data = d; rd_en = r;
    hold_req = h; release_req = rl; done = dn; addr_access = a;
  endtask

  task automatic chk(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.due = cyc; it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic idle();           drive(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [2:0] i, input logic [7:0] d); drive(1, i, d, 0, 0, 0, 0, 0); endtask
  task automatic rd(input logic [2:0] i, input logic [7:0] e, input string req);
    drive(0, i, 0, 1, 0, 0, 0, 0); chk(0, e, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 8'h00, "R1"); chk(1, 0, "R1"); chk(2, 0, "R1"); chk(3, 0, "R1"); chk(4, 0, "R1");
    rd(1, 8'h0F, "R1");
    // R3 request ch2 while masked
    wr(1, 8'h06); rd(0, 8'h40, "R3"); chk(1, 0, "R4");
    // R4 unmask ch2
    wr(2, 8'h02); rd(1, 8'h0B, "R4"); chk(1, 8'h04, "R12");
    wr(1, 8'h05); wr(2, 8'h01); idle(); chk(1, 8'h02, "R12");
    // R2 command filtering
    wr(0, 8'h04); idle(); chk(2, 1, "R2"); chk(1, 0, "R12");
    wr(0, 8'h14); idle(); chk(2, 1, "R2");
    wr(0, 8'h00); idle(); chk(2, 0, "R2"); chk(1, 8'h02, "R12");
    wr(0, 8'h01); wr(0, 8'h80); idle(); chk(2, 0, "R2");
    // R11 hold / release
    drive(0, 0, 0, 0, 4'b0001, 0, 0, 0); idle(); chk(1, 8'h02, "R11");
    wr(2, 8'h00); idle(); chk(1, 8'h01, "R11");
    drive(0, 0, 0, 0, 0, 4'b0001, 0, 0); idle(); chk(1, 8'h02, "R11");
    drive(0, 0, 0, 0, 4'b0001, 4'b0001, 0, 0); idle(); chk(1, 8'h02, "R11");
    drive(1, 1, 8'h03, 0, 4'b1000, 0, 0, 0); rd(0, 8'h60, "R11");
    // R10 / R9 terminal count
    drive(0, 0, 0, 0, 0, 0, 4'b0100, 0); rd(0, 8'h64, "R10"); rd(0, 8'h60, "R9");
    drive(0, 0, 0, 1, 0, 0, 4'b0001, 0); chk(0, 8'h60, "R9");
    rd(0, 8'h61, "R10"); rd(0, 8'h60, "R9");
    // R3 request write clears terminal count
    drive(0, 0, 0, 0, 0, 0, 4'b0010, 0); wr(1, 8'h05); rd(0, 8'h60, "R3");
    drive(0, 0, 0, 0, 0, 0, 4'b0110, 0); wr(1, 8'h01); rd(0, 8'h44, "R3");
    rd(0, 8'h40, "R9"); wr(1, 8'h05);
    // R5 mode bytes
    wr(3, 8'hB7); wr(3, 8'h48); idle();
    chk(7, 8'hB7, "R5"); chk(4, 8'h48, "R5"); chk(5, 8'h00, "R5");
    // R8 byte pointer
    drive(0, 0, 0, 0, 0, 0, 0, 1); idle(); chk(3, 1, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 1); idle(); chk(3, 0, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 1); wr(4, 8'h00); idle(); chk(3, 0, "R8");
    drive(0, 0, 0, 0, 0, 0, 0, 1); drive(1, 4, 0, 0, 0, 0, 0, 1); idle(); chk(3, 0, "R8");
    // R7 whole-mask writes
    wr(7, 8'hAE); rd(1, 8'h0E, "R7"); chk(1, 0, "R7");
    wr(6, 8'h00); rd(1, 8'h00, "R7"); chk(1, 8'h02, "R12");
    // R6 master clear
    drive(0, 0, 0, 0, 0, 0, 0, 1); wr(0, 8'h04); drive(0, 0, 0, 0, 0, 0, 4'b0001, 0);
    idle(); chk(3, 1, "R8");
    wr(5, 8'h00); rd(0, 8'h00, "R6"); chk(2, 0, "R6"); chk(3, 0, "R6");
    chk(7, 8'hB7, "R6"); chk(1, 0, "R6");
    rd(1, 8'h0F, "R6");
    // R9 other indices read zero
    rd(3, 8'h00, "R9"); rd(7, 8'h00, "R9"); rd(2, 8'h00, "R9");
    repeat (3) idle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule